// File: doc/BRIEF.md
# PAL output macrocell

This block is one output cell of a small sum-of-products programmable logic device. It receives the product terms that the AND array has already formed for it and ORs them into one sum. It applies a selectable polarity to that sum. It then presents the result to a tri-state pad and returns a feedback bit to the array. Two mode bits are shared by the whole device and two bits belong to the cell. Together they pick one of four behaviours: a clocked (registered) output, a combinatorial I/O whose enable comes from a product term, an always-driving combinatorial output, or a plain input.

The pad is modelled as a driven value `pad_out`, an enable `pad_oe` and a sensed value `pad_in`. `pad_out` is forced to 0 whenever the driver is off. The flip-flop has two extra paths that take priority over the sum: a synchronous reset, which models power-up clearing, and a synchronous preload for test. A build parameter marks the cell as one of the two centre cells of the device. Those cells cannot act as inputs and give no feedback when they are plain outputs.

Top module: `pal_macrocell`

## Requirements
- R1: With `dev_sel0`=1, `dev_sel1`=1 and `cell_sel`=0 (registered mode), `pad_out` after a rising edge equals the polarity-adjusted OR of `terms` sampled at that edge, and `pad_oe` equals `glob_oe`.
- R2: `cell_pol_hi`=1 makes the cell active high (the value is the OR of the terms); `cell_pol_hi`=0 inverts it. This holds in every driving mode.
- R3: With `dev_sel1`=1 and either `dev_sel0`=0 or `cell_sel`=1 (combinatorial I/O), `pad_out` is the polarity-adjusted sum in the same cycle, `pad_oe` equals `oe_term`, and `fb` equals `pad_in`.
- R4: With `dev_sel0`=1, `dev_sel1`=0 and `cell_sel`=0 (dedicated output), `pad_oe` is 1 and `pad_out` is the polarity-adjusted sum. `fb` equals `pad_in` on an outer cell and is 0 on a centre cell.
- R5: With `dev_sel0`=1, `dev_sel1`=0 and `cell_sel`=1 (dedicated input), `pad_oe` is 0 and `fb` equals `pad_in`. A centre cell rejects this mode: it keeps `pad_oe` at 0 and `fb` at 0.
- R6: In registered mode `fb` carries the register's pad-side value, whatever the value of `glob_oe`.
- R7: A cycle with `rst`=1 clears the flip-flop. After it, the registered `pad_out` reads 1 under both polarity settings.
- R8: A cycle with `preload_en`=1 (and `rst`=0) loads the register so that the registered pad shows `preload_val`, whatever the terms are. When both are high, `rst` wins.
- R9: The setting `dev_sel0`=0 with `dev_sel1`=0 is unused. In it `pad_oe` is 0, `pad_out` is 0 and `fb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset (power-up clear) |
| dev_sel0 | input | 1 | Device-wide mode bit 0 |
| dev_sel1 | input | 1 | Device-wide mode bit 1 |
| cell_sel | input | 1 | Per-cell mode bit |
| cell_pol_hi | input | 1 | Per-cell polarity, 1 = active high |
| terms | input | NTERMS | Product terms from the AND array |
| oe_term | input | 1 | Enable product term for combinatorial I/O |
| glob_oe | input | 1 | Device-level enable for registered outputs |
| preload_en | input | 1 | Test preload strobe |
| preload_val | input | 1 | Pad value to preload |
| pad_in | input | 1 | Value sensed on the pad |
| pad_out | output | 1 | Value driven to the pad (0 when disabled) |
| pad_oe | output | 1 | Pad driver enable |
| fb | output | 1 | Feedback bit returned to the array |

## Verification
The temporal properties assume that the mode bits and the polarity bit hold their values across the clock edge they refer to. This is the case in a programmed device, where configuration is static. The bench therefore changes configuration only on falling edges and holds it through the next rising edge. The reset and preload properties refer to the previous cycle only. Because the bench opens with a reset cycle, that previous cycle is always defined. Every combination of the four configuration bits is driven against both an outer and a centre instance, with each sum value and each pad value.

// File: rtl/pal_mc_pkg.sv
package pal_mc_pkg;

    typedef enum logic [2:0] {
        MC_REG  = 3'd0,
        MC_CIO  = 3'd1,
        MC_COUT = 3'd2,
        MC_DIN  = 3'd3,
        MC_OFF  = 3'd4
    } mc_mode_e;

    typedef struct packed {
        logic data;
        logic oe;
        logic fb;
    } mc_drive_t;

    function automatic mc_mode_e mc_decode(input logic g0, input logic g1,
                                           input logic l0, input bit centre);
        mc_mode_e m;
        unique case ({g0, g1})
            2'b11:   m = l0 ? MC_CIO : MC_REG;
            2'b01:   m = MC_CIO;
            2'b10:   m = l0 ? (centre ? MC_OFF : MC_DIN) : MC_COUT;
            default: m = MC_OFF;
        endcase
        return m;
    endfunction

    function automatic logic mc_polarize(input logic sum, input logic pol_hi);
        return pol_hi ? sum : ~sum;
    endfunction

endpackage

// File: rtl/pal_mc_decode.sv
module pal_mc_decode
    import pal_mc_pkg::*;
#(
    parameter bit CENTRE = 1'b0
) (
    input  logic     dev_sel0,
    input  logic     dev_sel1,
    input  logic     cell_sel,
    output mc_mode_e mode,
    output logic     cout_fb_en
);
    localparam bit FB_IN_COUT = !CENTRE;

    always_comb begin
        mode       = mc_decode(dev_sel0, dev_sel1, cell_sel, CENTRE);
        cout_fb_en = FB_IN_COUT;
    end
endmodule

// File: rtl/pal_mc_sum.sv
module pal_mc_sum
    import pal_mc_pkg::*;
#(
    parameter int NTERMS = 8
) (
    input  logic [NTERMS-1:0] terms,
    input  logic              pol_hi,
    output logic              value
);
    localparam int LAST = NTERMS - 1;

    logic [LAST:0] chain;

    generate
        for (genvar i = 0; i < NTERMS; i++) begin : g_or
            if (i == 0) begin : g_first
                assign chain[i] = terms[i];
            end else begin : g_next
                assign chain[i] = chain[i-1] | terms[i];
            end
        end
    endgenerate

    assign value = mc_polarize(chain[LAST], pol_hi);
endmodule

// File: rtl/pal_mc_reg.sv
module pal_mc_reg (
    input  logic clk,
    input  logic rst,
    input  logic preload_en,
    input  logic preload_val,
    input  logic d_pad,
    output logic q_pad
);
    // The flip-flop stores the complement of the pad value, so a cleared
    // register appears as a high pad.
    logic q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (preload_en) begin
            q <= ~preload_val;
        end else begin
            q <= ~d_pad;
        end
    end

    assign q_pad = ~q;
endmodule

// File: rtl/pal_mc_route.sv
module pal_mc_route
    import pal_mc_pkg::*;
(
    input  mc_mode_e  mode,
    input  logic      cout_fb_en,
    input  logic      comb_val,
    input  logic      reg_pad,
    input  logic      oe_term,
    input  logic      glob_oe,
    input  logic      pad_in,
    output mc_drive_t drv
);
    always_comb begin
        drv = '0;
        unique case (mode)
            MC_REG: begin
                drv.oe   = glob_oe;
                drv.data = glob_oe & reg_pad;
                drv.fb   = reg_pad;
            end
            MC_CIO: begin
                drv.oe   = oe_term;
                drv.data = oe_term & comb_val;
                drv.fb   = pad_in;
            end
            MC_COUT: begin
                drv.oe   = 1'b1;
                drv.data = comb_val;
                drv.fb   = cout_fb_en & pad_in;
            end
            MC_DIN: begin
                drv.fb   = pad_in;
            end
            default: begin
                drv = '0;
            end
        endcase
    end
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
    import pal_mc_pkg::*;
#(
    parameter int NTERMS = 8,
    parameter bit CENTRE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dev_sel0,
    input  logic              dev_sel1,
    input  logic              cell_sel,
    input  logic              cell_pol_hi,
    input  logic [NTERMS-1:0] terms,
    input  logic              oe_term,
    input  logic              glob_oe,
    input  logic              preload_en,
    input  logic              preload_val,
    input  logic              pad_in,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              fb
);
    mc_mode_e  mode;
    logic      cout_fb_en;
    logic      comb_val;
    logic      reg_pad;
    mc_drive_t drv;

    pal_mc_decode #(.CENTRE(CENTRE)) u_decode (
        .dev_sel0   (dev_sel0),
        .dev_sel1   (dev_sel1),
        .cell_sel   (cell_sel),
        .mode       (mode),
        .cout_fb_en (cout_fb_en)
    );

    pal_mc_sum #(.NTERMS(NTERMS)) u_sum (
        .terms  (terms),
        .pol_hi (cell_pol_hi),
        .value  (comb_val)
    );

    pal_mc_reg u_reg (
        .clk         (clk),
        .rst         (rst),
        .preload_en  (preload_en),
        .preload_val (preload_val),
        .d_pad       (comb_val),
        .q_pad       (reg_pad)
    );

    pal_mc_route u_route (
        .mode       (mode),
        .cout_fb_en (cout_fb_en),
        .comb_val   (comb_val),
        .reg_pad    (reg_pad),
        .oe_term    (oe_term),
        .glob_oe    (glob_oe),
        .pad_in     (pad_in),
        .drv        (drv)
    );

    assign pad_out = drv.data;
    assign pad_oe  = drv.oe;
    assign fb      = drv.fb;
endmodule

// File: rtl/pal_macrocell_chk.sv
module pal_macrocell_chk #(
    parameter int NTERMS = 8,
    parameter bit CENTRE = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              dev_sel0,
    input logic              dev_sel1,
    input logic              cell_sel,
    input logic              cell_pol_hi,
    input logic [NTERMS-1:0] terms,
    input logic              oe_term,
    input logic              glob_oe,
    input logic              preload_en,
    input logic              preload_val,
    input logic              pad_in,
    input logic              pad_out,
    input logic              pad_oe,
    input logic              fb
);
    logic is_reg, is_cio, is_cout, is_din, is_off, any_term;

    assign is_reg   = dev_sel0 & dev_sel1 & ~cell_sel;
    assign is_cio   = dev_sel1 & (~dev_sel0 | cell_sel);
    assign is_cout  = dev_sel0 & ~dev_sel1 & ~cell_sel;
    assign is_din   = dev_sel0 & ~dev_sel1 & cell_sel;
    assign is_off   = ~dev_sel0 & ~dev_sel1;
    assign any_term = |terms;

    // R1
    reg_follows_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (is_reg && glob_oe && !$past(rst) && !$past(preload_en)) |->
        (pad_out == ($past(cell_pol_hi) ? $past(any_term) : !$past(any_term))));

    // R2
    cout_polarity_chk: assert property (@(posedge clk) disable iff (rst)
        is_cout |-> (pad_out == (cell_pol_hi ? any_term : !any_term)));

    // R3
    cio_route_chk: assert property (@(posedge clk) disable iff (rst)
        is_cio |-> (pad_oe == oe_term && fb == pad_in));

    // R4
    cout_drive_chk: assert property (@(posedge clk) disable iff (rst)
        is_cout |-> (pad_oe && (CENTRE ? !fb : fb == pad_in)));

    // R5
    din_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        is_din |-> (!pad_oe && (CENTRE ? !fb : fb == pad_in)));

    // R6
    reg_fb_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (is_reg && $past(rst)) |-> fb);

    // R7
    reset_pad_high_chk: assert property (@(posedge clk) disable iff (rst)
        (is_reg && glob_oe && $past(rst)) |-> pad_out);

    // R8
    preload_chk: assert property (@(posedge clk) disable iff (rst)
        (is_reg && glob_oe && $past(preload_en) && !$past(rst)) |->
        (pad_out == $past(preload_val)));

    // R9
    off_mode_chk: assert property (@(posedge clk) disable iff (rst)
        is_off |-> (!pad_oe && !pad_out && !fb));
endmodule

bind pal_macrocell pal_macrocell_chk #(.NTERMS(NTERMS), .CENTRE(CENTRE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dev_sel0    (dev_sel0),
    .dev_sel1    (dev_sel1),
    .cell_sel    (cell_sel),
    .cell_pol_hi (cell_pol_hi),
    .terms       (terms),
    .oe_term     (oe_term),
    .glob_oe     (glob_oe),
    .preload_en  (preload_en),
    .preload_val (preload_val),
    .pad_in      (pad_in),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .fb          (fb)
);

// File: tb/test_pal_macrocell.sv
module test_pal_macrocell;
    localparam int NT = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic g0 = 1'b1, g1 = 1'b1, l0 = 1'b0, pol = 1'b1;
    logic [NT-1:0] terms = '0;
    logic oet = 1'b0, goe = 1'b1, pl = 1'b0, plv = 1'b0, pin = 1'b0;
    logic out_o, oe_o, fb_o, out_c, oe_c, fb_c;

    int checks = 0;
    int errors = 0;
    logic model_reg = 1'b1;

    typedef struct {
        logic  o, oe, f, oc, oec, fc;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    pal_macrocell #(.NTERMS(NT), .CENTRE(1'b0)) i_pal_macrocell (
        .clk(clk), .rst(rst), .dev_sel0(g0), .dev_sel1(g1), .cell_sel(l0),
        .cell_pol_hi(pol), .terms(terms), .oe_term(oet), .glob_oe(goe),
        .preload_en(pl), .preload_val(plv), .pad_in(pin),
        .pad_out(out_o), .pad_oe(oe_o), .fb(fb_o));

    pal_macrocell #(.NTERMS(NT), .CENTRE(1'b1)) i_pal_macrocell_ctr (
        .clk(clk), .rst(rst), .dev_sel0(g0), .dev_sel1(g1), .cell_sel(l0),
        .cell_pol_hi(pol), .terms(terms), .oe_term(oet), .glob_oe(goe),
        .preload_en(pl), .preload_val(plv), .pad_in(pin),
        .pad_out(out_c), .pad_oe(oe_c), .fb(fb_c));

    // Expected pad/enable/feedback from the requirements, given the
    // register's pad value after the coming edge.
    task automatic expect_cell(input bit centre, input logic regv,
                               output logic o, output logic e, output logic f);
        logic pv;
        pv = pol ? (|terms) : ~(|terms);
        o = 1'b0; e = 1'b0; f = 1'b0;
        if (g0 && g1 && !l0) begin               // R1 registered
            e = goe; o = goe & regv; f = regv;
        end else if (g1) begin                   // R3 combinatorial I/O
            e = oet; o = oet & pv; f = pin;
        end else if (g0 && !l0) begin            // R4 dedicated output
            e = 1'b1; o = pv; f = centre ? 1'b0 : pin;
        end else if (g0) begin                   // R5 dedicated input
            f = centre ? 1'b0 : pin;
        end                                      // R9 otherwise all zero
    endtask

    task automatic drive(input logic a0, input logic a1, input logic s0,
                         input logic p, input logic [NT-1:0] t,
                         input logic oterm, input logic gen,
                         input logic pre, input logic prev,
                         input logic pi, input logic r, input string tag);
        exp_t it;
        @(negedge clk);
        g0 = a0; g1 = a1; l0 = s0; pol = p; terms = t; oet = oterm;
        goe = gen; pl = pre; plv = prev; pin = pi; rst = r;
        if (r)        model_reg = 1'b1;
        else if (pre) model_reg = prev;
        else          model_reg = p ? (|t) : ~(|t);
        expect_cell(1'b0, model_reg, it.o, it.oe, it.f);
        expect_cell(1'b1, model_reg, it.oc, it.oec, it.fc);
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic cmp(input string tag, input string what,
                       input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // Monitor: compare after each rising edge, before inputs change.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                cmp(it.tag, "pad_out",     out_o, it.o);
                cmp(it.tag, "pad_oe",      oe_o,  it.oe);
                cmp(it.tag, "fb",          fb_o,  it.f);
                cmp(it.tag, "ctr pad_out", out_c, it.oc);
                cmp(it.tag, "ctr pad_oe",  oe_c,  it.oec);
                cmp(it.tag, "ctr fb",      fb_c,  it.fc);
            end
        end
    end

    function automatic string mode_tag(input logic a0, input logic a1,
                                       input logic s0, input logic p);
        string s;
        if (a0 && a1 && !s0) s = "R1";
        else if (a1)         s = "R3";
        else if (a0 && !s0)  s = "R4";
        else if (a0)         s = "R5";
        else                 s = "R9";
        if (!p) s = {s, "/R2"};
        return s;
    endfunction

    initial begin
        // R7: reset leaves the registered pad high under both polarities
        drive(1, 1, 0, 0, 8'hFF, 0, 1, 0, 0, 0, 1, "R7 pol low");
        drive(1, 1, 0, 1, 8'h00, 0, 1, 0, 0, 0, 1, "R7 pol high");
        // R1/R2: registered operation
        drive(1, 1, 0, 1, 8'h10, 0, 1, 0, 0, 0, 0, "R1");
        drive(1, 1, 0, 1, 8'h00, 0, 1, 0, 0, 0, 0, "R1");
        drive(1, 1, 0, 0, 8'h00, 0, 1, 0, 0, 0, 0, "R1/R2");
        drive(1, 1, 0, 0, 8'h81, 0, 1, 0, 0, 1, 0, "R1/R2");
        // R6: feedback with the global enable off
        drive(1, 1, 0, 0, 8'h00, 1, 0, 0, 0, 0, 0, "R6");
        drive(1, 1, 0, 1, 8'h00, 1, 0, 0, 0, 1, 0, "R6");
        // R8: preload overrides terms; reset wins over preload
        drive(1, 1, 0, 1, 8'hFF, 0, 1, 1, 0, 0, 0, "R8 load 0");
        drive(1, 1, 0, 0, 8'hFF, 0, 1, 1, 1, 0, 0, "R8 load 1");
        drive(1, 1, 0, 1, 8'h00, 0, 1, 1, 1, 0, 0, "R8 load 1 hold");
        drive(1, 1, 0, 1, 8'h00, 0, 1, 1, 0, 0, 1, "R8/R7 reset wins");
        drive(1, 1, 0, 1, 8'h02, 0, 1, 0, 0, 0, 0, "R1 after reset");

        // Every configuration with each sum and pad value
        for (int g = 0; g < 4; g++) begin
            for (int s0 = 0; s0 < 2; s0++) begin
                for (int p = 0; p < 2; p++) begin
                    for (int sm = 0; sm < 2; sm++) begin
                        for (int pi = 0; pi < 2; pi++) begin
                            logic [NT-1:0] t;
                            logic a0, a1;
                            a0 = g[0]; a1 = g[1];
                            t = sm[0] ? (NT'(1) << ((g + s0 + pi) % NT)) : '0;
                            drive(a0, a1, s0[0], p[0], t, sm[0] ^ pi[0],
                                  pi[0] | s0[0], 1'b0, 1'b0, pi[0], 1'b0,
                                  mode_tag(a0, a1, s0[0], p[0]));
                        end
                    end
                end
            end
        end

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule